// File: doc/BRIEF.md
# Rail Fault Supervisor

This block is the protection core of a supply controller that runs one switching core rail and three linear rails. It receives already synchronised fault flags: core overcurrent, core overvoltage, and undervoltage on rails 2, 3 and 4. It also receives two "ramp capacitor charged" flags from the start-up sequencer, a flag that says the slow ramp capacitor has drained low, a flag that says the core output is above the pre-bias clamp level, and a bias-power-good input. From these it decides whether to inhibit rails 1 to 3, whether to ask the sequencer to empty both ramp capacitors, whether to hold the low-side switch on, and whether to raise the fault pin.

Each kind of fault takes its own path. Core overvoltage and a rail 4 undervoltage shut the controller down for good. A core overcurrent, or an undervoltage on rail 2 or rail 3, starts a retry instead. The retry inhibits rails 1 to 3 and empties the ramp capacitors, and the block releases the rails again once the slow capacitor reports low. Two separate strike counters track these retries. The third retry in a row on either counter becomes a permanent shutdown. A clean start-up clears both counters, and losing bias power clears everything.

Top module: `rail_fault_supervisor`

## Requirements
- R1: While bias_ok is low, rail_inhibit is high and fault_pin is low. Dropping bias_ok for one cycle clears the permanent latch, the retry latch and both strike counters.
- R2: With bias_ok high, a core_ov input sets the permanent latch at the next clock edge. After that edge, fault_pin, rail_inhibit, ss_fast_dump and ss_slow_drain are all high.
- R3: lowside_clamp is high whenever bias_ok and core_ov are both high, or whenever bias_ok is low and core_hi_prebias is high. core_hi_prebias has no effect while bias_ok is high.
- R4: A uv4 input sets the permanent latch only while ss_b_full is high. While ss_b_full is low, uv4 is ignored.
- R5: A core_oc input while no latch is set starts a retry at the next edge. rail_inhibit, ss_fast_dump and ss_slow_drain go high, and fault_pin stays low while the strike count is below three.
- R6: uv2 counts as an event only while ss_b_full is high, and uv3 only while ss_a_full is high. Outside those windows neither one has any effect.
- R7: While a retry is active and no permanent trip occurs, ss_b_low ends the retry at the next edge and rail_inhibit falls.
- R8: Events that occur while a retry is active are not counted, so a fault that persists is counted once per retry.
- R9: The third counted event on either strike counter sets the permanent latch at the edge where it is accepted.
- R10: The overcurrent counter and the undervoltage counter (uv2 or uv3) run independently. Two strikes on each do not trip the permanent latch.
- R11: A cycle in which ss_a_full and ss_b_full are both high, with no latch set and no event present, clears both counters.
- R12: Once the permanent latch is set, only the loss of bias clears it. ss_b_low does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bias_ok | input | 1 | Bias supply above its power-on level |
| core_oc | input | 1 | Core overcurrent flag |
| core_ov | input | 1 | Core overvoltage flag |
| uv2 | input | 1 | Rail 2 undervoltage flag |
| uv3 | input | 1 | Rail 3 undervoltage flag |
| uv4 | input | 1 | Rail 4 undervoltage flag |
| ss_a_full | input | 1 | Fast ramp capacitor fully charged |
| ss_b_full | input | 1 | Slow ramp capacitor fully charged |
| ss_b_low | input | 1 | Slow ramp capacitor drained below restart level |
| core_hi_prebias | input | 1 | Core output above the pre-bias clamp level |
| rail_inhibit | output | 1 | Turn off rails 1 to 3 |
| ss_fast_dump | output | 1 | Request a quick discharge of the fast ramp capacitor |
| ss_slow_drain | output | 1 | Request a slow discharge of the slow ramp capacitor |
| lowside_clamp | output | 1 | Hold the core low-side switch on |
| fault_pin | output | 1 | Fault indication, driven high when the permanent latch is set |

## Verification
The bound checker tests the edge-to-edge rules on every cycle. These are: an overvoltage trips the latch at the next edge, a set latch holds while bias stays up, bias loss clears it, an overcurrent starts a retry, a drained slow capacitor ends the retry, and the latch stays low when no event source is active. Strike counting can only be shown by the bench's scenarios, because the counters are not visible at the ports. Those scenarios cover a fault held across one retry that is counted once, the third strike on each counter, the two counters staying independent, a clean start-up clearing the count, and the blanking of uv2, uv3 and uv4 by their ramp flags.

// File: rtl/rail_fault_supervisor.sv
module rail_fault_supervisor #(
  parameter int STRIKES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bias_ok,
  input  logic core_oc,
  input  logic core_ov,
  input  logic uv2,
  input  logic uv3,
  input  logic uv4,
  input  logic ss_a_full,
  input  logic ss_b_full,
  input  logic ss_b_low,
  input  logic core_hi_prebias,
  output logic rail_inhibit,
  output logic ss_fast_dump,
  output logic ss_slow_drain,
  output logic lowside_clamp,
  output logic fault_pin
);
  localparam int CW = $clog2(STRIKES + 1);

  logic       retry_q, fault_q;
  logic [1:0] evt, hit;
  logic       accept, start_ok, perm_trip;

  assign evt[0]   = core_oc;
  assign evt[1]   = (uv2 & ss_b_full) | (uv3 & ss_a_full);
  assign accept   = bias_ok & ~retry_q & ~fault_q;
  assign start_ok = ss_a_full & ss_b_full & ~retry_q & ~fault_q & ~|evt;

  for (genvar g = 0; g < 2; g++) begin : g_strike
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               cnt_q <= '0;
      else if (!bias_ok)                        cnt_q <= '0;
      else if (accept && evt[g] && cnt_q != CW'(STRIKES)) cnt_q <= cnt_q + 1'b1;
      else if (start_ok)                        cnt_q <= '0;
    end
    assign hit[g] = accept & evt[g] & (cnt_q == CW'(STRIKES - 1));
  end

  assign perm_trip = core_ov | (uv4 & ss_b_full) | (|hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         fault_q <= 1'b0;
    else if (!bias_ok)  fault_q <= 1'b0;
    else if (perm_trip) fault_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                retry_q <= 1'b0;
    else if (!bias_ok)         retry_q <= 1'b0;
    else if (accept && |evt)   retry_q <= 1'b1;
    else if (ss_b_low)         retry_q <= 1'b0;
  end

  assign rail_inhibit  = retry_q | fault_q | ~bias_ok;
  assign ss_fast_dump  = retry_q | fault_q;
  assign ss_slow_drain = retry_q | fault_q;
  assign lowside_clamp = bias_ok ? core_ov : core_hi_prebias;
  assign fault_pin     = fault_q;
endmodule

module rail_fault_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic bias_ok,
  input logic core_oc,
  input logic core_ov,
  input logic uv2,
  input logic uv3,
  input logic uv4,
  input logic ss_a_full,
  input logic ss_b_full,
  input logic ss_b_low,
  input logic rail_inhibit,
  input logic ss_slow_drain,
  input logic fault_pin
);
  p_ov_trip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bias_ok && core_ov) |=> fault_pin);

  p_latch_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bias_ok && fault_pin) |=> fault_pin);

  p_bias_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !bias_ok |=> !fault_pin);

  p_oc_retry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bias_ok && core_oc && !rail_inhibit) |=> (rail_inhibit && ss_slow_drain));

  p_drain_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bias_ok && ss_b_low && ss_slow_drain && !fault_pin && !core_ov && !(uv4 && ss_b_full))
      |=> !ss_slow_drain);

  p_blank_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_pin && !core_ov && !core_oc && !(uv2 && ss_b_full) && !(uv3 && ss_a_full)
      && !(uv4 && ss_b_full)) |=> !fault_pin);
endmodule

bind rail_fault_supervisor rail_fault_supervisor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bias_ok(bias_ok), .core_oc(core_oc), .core_ov(core_ov),
  .uv2(uv2), .uv3(uv3), .uv4(uv4), .ss_a_full(ss_a_full), .ss_b_full(ss_b_full),
  .ss_b_low(ss_b_low), .rail_inhibit(rail_inhibit), .ss_slow_drain(ss_slow_drain),
  .fault_pin(fault_pin)
);

// File: tb/rail_fault_supervisor_test.sv
module rail_fault_supervisor_test;
  localparam logic [9:0] S_B   = 10'h200;
  localparam logic [9:0] S_OC  = 10'h100;
  localparam logic [9:0] S_OV  = 10'h080;
  localparam logic [9:0] S_U2  = 10'h040;
  localparam logic [9:0] S_U3  = 10'h020;
  localparam logic [9:0] S_U4  = 10'h010;
  localparam logic [9:0] S_AF  = 10'h008;
  localparam logic [9:0] S_BF  = 10'h004;
  localparam logic [9:0] S_BL  = 10'h002;
  localparam logic [9:0] S_PH  = 10'h001;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [9:0] stim = '0;
  logic rail_inhibit, ss_fast_dump, ss_slow_drain, lowside_clamp, fault_pin;
  int total = 0, bad = 0;
  bit done = 0;
  string      tag_q[$];
  logic [4:0] exp_q[$];

  always #4 clk = ~clk;

  rail_fault_supervisor uut (
    .clk(clk), .rst_n(rst_n), .bias_ok(stim[9]), .core_oc(stim[8]), .core_ov(stim[7]),
    .uv2(stim[6]), .uv3(stim[5]), .uv4(stim[4]), .ss_a_full(stim[3]), .ss_b_full(stim[2]),
    .ss_b_low(stim[1]), .core_hi_prebias(stim[0]),
    .rail_inhibit(rail_inhibit), .ss_fast_dump(ss_fast_dump), .ss_slow_drain(ss_slow_drain),
    .lowside_clamp(lowside_clamp), .fault_pin(fault_pin)
  );

  // Output vector: {inhibit, fast_dump, slow_drain, clamp, fault_pin}
  task automatic step(input string tag, input logic [9:0] s, input logic [4:0] e);
    stim = s;
    @(posedge clk);
    #1;
    tag_q.push_back(tag);
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    #3;
    if (exp_q.size() > 0) begin
      automatic logic [4:0] got = {rail_inhibit, ss_fast_dump, ss_slow_drain, lowside_clamp, fault_pin};
      automatic logic [4:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      total++;
      if (got !== e) begin
        bad++;
        $display("FAIL %s: got %b expected %b", t, got, e);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step("R1 reset, bias low", '0, 5'b10000);
    step("R3 prebias clamp", S_PH, 5'b10010);
    step("R1 bias up idle", S_B, 5'b00000);
    step("R3 prebias ignored with bias", S_B | S_PH, 5'b00000);
    step("R5 oc starts retry", S_B | S_OC, 5'b11100);
    step("R8 held oc", S_B | S_OC, 5'b11100);
    step("R8 held oc again", S_B | S_OC, 5'b11100);
    step("R7 drain low ends retry", S_B | S_BL, 5'b00000);
    step("R5 second oc", S_B | S_OC, 5'b11100);
    step("R7 release", S_B | S_BL, 5'b00000);
    step("R6 uv2 blanked", S_B | S_U2, 5'b00000);
    step("R6 uv3 blanked by a flag", S_B | S_U3 | S_BF, 5'b00000);
    step("R10 uv2 counted", S_B | S_U2 | S_BF, 5'b11100);
    step("R10 release", S_B | S_BL, 5'b00000);
    step("R9 third oc trips", S_B | S_OC, 5'b11101);
    step("R12 drain low keeps latch", S_B | S_BL, 5'b11101);
    step("R1 bias drop", '0, 5'b10000);
    step("R1 bias back clear", S_B, 5'b00000);

    step("R11 oc1", S_B | S_OC, 5'b11100);
    step("R11 rel", S_B | S_BL, 5'b00000);
    step("R11 oc2", S_B | S_OC, 5'b11100);
    step("R11 rel", S_B | S_BL, 5'b00000);
    step("R11 clean start", S_B | S_AF | S_BF, 5'b00000);
    step("R11 oc after clear", S_B | S_OC, 5'b11100);
    step("R11 rel", S_B | S_BL, 5'b00000);
    step("R11 oc second after clear", S_B | S_OC, 5'b11100);
    step("R11 rel", S_B | S_BL, 5'b00000);
    step("R9 oc third since clear", S_B | S_OC, 5'b11101);
    step("R1 bias drop", '0, 5'b10000);

    step("R6 uv3 counted 1", S_B | S_U3 | S_AF, 5'b11100);
    step("R7 rel", S_B | S_BL, 5'b00000);
    step("R6 uv3 counted 2", S_B | S_U3 | S_AF, 5'b11100);
    step("R7 rel", S_B | S_BL, 5'b00000);
    step("R9 uv3 third trips", S_B | S_U3 | S_AF, 5'b11101);
    step("R1 bias drop", '0, 5'b10000);

    step("R2 ov trips", S_B | S_OV, 5'b11111);
    step("R2 latch after ov", S_B, 5'b11101);
    step("R1 bias drop", '0, 5'b10000);

    step("R4 uv4 blanked", S_B | S_U4, 5'b00000);
    step("R4 uv4 trips", S_B | S_U4 | S_BF, 5'b11101);
    step("R1 bias drop", '0, 5'b10000);
    step("R1 final idle", S_B, 5'b00000);

    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule